// File: doc/BRIEF.md
# Byte-Masked Message Word Packer with Bit-Length Counter

This block sits between a write bus and the message FIFO of a hashing engine. A write into the message address window is turned into one downstream word together with the mask of the byte lanes the bus enabled. The block can optionally reverse the byte order of each write, so that a multi-byte value stored by software lands in the message in big-endian order. Writes made one byte at a time look the same in either setting.

Every append the FIFO accepts adds eight bits per enabled byte to a 64-bit running length. The length is presented as two 32-bit halves. A start pulse clears it at the beginning of a new message. When the FIFO cannot take a word, the block holds the bus ready low. The write then waits in place until the FIFO frees up. Writes that fall outside the window are acknowledged at once and dropped.

Top module: `msg_packer`

## Requirements
- R1: A write whose byte address lies in the window 0x800..0xFFF (12-bit address) with at least one byte enable set is forwarded as one downstream word. The address bits inside the window, [1:0] included, do not change the word that is forwarded.
- R2: A write outside the window is acknowledged in the same cycle (wr_ready_o high), produces no downstream word and leaves the length unchanged.
- R3: With swap_en_i low, each enabled byte lane of out_data_o carries the same lane of wr_data_i, and each disabled lane is driven with zero. Lane i is bits [8i+7:8i].
- R4: With swap_en_i high, the enabled bytes are reversed among the enabled lanes. The k-th enabled lane counted up from lane 0 receives the k-th enabled byte counted down from lane 3, and disabled lanes read zero. For example, 0x44332211 with all lanes enabled becomes 0x11223344, and 0x00332211 with mask 0111 becomes 0x00112233.
- R5: A write with exactly one enabled lane yields the same word whichever value swap_en_i has.
- R6: out_mask_o equals the write's byte enables, bit i standing for lane i, and out_valid_o is only high while wr_valid_i is high.
- R7: While out_ready_i is low, an in-window write with a nonzero mask keeps wr_ready_o low and is not counted. It completes in the cycle out_ready_i is high.
- R8: Each accepted append adds 8 times the number of enabled bytes to the 64-bit length. The length is shown as len_lo_o (bits 31:0) and len_hi_o (bits 63:32), and its bits [2:0] stay zero.
- R9: A start_i pulse sets the length to zero at the next edge. A write accepted in that same cycle is counted from zero.
- R10: An in-window write with all byte enables low is acknowledged at once. It produces no downstream word and adds nothing to the length.
- R11: After reset the length reads zero, and out_valid_o is low while no write is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | New-message pulse, clears the length |
| swap_en_i | input | 1 | Reverse the byte order of each write |
| wr_valid_i | input | 1 | Bus write request |
| wr_ready_o | output | 1 | Bus write acknowledge |
| wr_addr_i | input | 12 | Byte address of the write |
| wr_data_i | input | 32 | Write data, lane i in bits [8i+7:8i] |
| wr_be_i | input | 4 | Byte enables, bit i for lane i |
| out_valid_o | output | 1 | Downstream word valid |
| out_ready_i | input | 1 | Downstream FIFO can accept |
| out_data_o | output | 32 | Packed word |
| out_mask_o | output | 4 | Lanes of the word that hold message bytes |
| len_lo_o | output | 32 | Message length in bits, low half |
| len_hi_o | output | 32 | Message length in bits, high half |

## Verification
The hardest case to set up is a start pulse that arrives while a write is stalled by a full FIFO. In that case the clear and the delayed append must come out as "zero, then only the stalled bytes". The bench holds out_ready_i low under an in-window write for several cycles and pulses start_i in the first stalled cycle. It checks that the bus stays unacknowledged and that the length drops to zero. It then releases the FIFO and checks that the word and a length of just that write's bits arrive. Swapped writes with sparse masks such as 1010 and 0111 cover the reversal among non-adjacent lanes.

// File: rtl/msg_packer_pkg.sv
package msg_packer_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/msg_rst_sync.sv
module msg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/msg_window_decode.sv
module msg_window_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_LO = 12'h800,
  parameter logic [ADDR_W-1:0] WIN_HI = 12'hFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  always_comb begin
    in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
  end
endmodule

// File: rtl/msg_lane_swap.sv
module msg_lane_swap
  import msg_packer_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    swap_en,
  input  logic [BYTE_W*LANES-1:0] din,
  input  logic [LANES-1:0]        be,
  output logic [BYTE_W*LANES-1:0] dout
);
  localparam int unsigned CW = $clog2(LANES + 1);

  // rank[i]: number of enabled lanes below lane i
  logic [CW-1:0] rank [LANES];
  logic [CW-1:0] total;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      rank[i] = acc;
      acc = acc + CW'(be[i]);
    end
    total = acc;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t pick;
    always_comb begin
      pick = '0;
      for (int j = 0; j < LANES; j++) begin
        if (be[j] && (rank[j] == CW'(total - CW'(1) - rank[g]))) begin
          pick = din[j*BYTE_W +: BYTE_W];
        end
      end
      if (!be[g]) begin
        dout[g*BYTE_W +: BYTE_W] = '0;
      end else if (swap_en) begin
        dout[g*BYTE_W +: BYTE_W] = pick;
      end else begin
        dout[g*BYTE_W +: BYTE_W] = din[g*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/msg_len_counter.sv
module msg_len_counter #(
  parameter int unsigned LEN_W = 64,
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [LANES-1:0] be,
  output logic [LEN_W-1:0] len_bits
);
  localparam int unsigned BW = LEN_W - 3;
  localparam int unsigned CW = $clog2(LANES + 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] nbytes;

  always_comb begin
    nbytes = '0;
    for (int i = 0; i < LANES; i++) begin
      nbytes = nbytes + CW'(be[i]);
    end
  end

  always_comb begin
    logic [BW-1:0] base;
    base   = clear ? '0 : cnt_q;
    cnt_d  = add_en ? (base + BW'(nbytes)) : base;
    cnt_en = clear | add_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign len_bits = {cnt_q, 3'b000};
endmodule

// File: rtl/msg_packer.sv
module msg_packer
  import msg_packer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_LO = 12'h800,
  parameter logic [ADDR_W-1:0] WIN_HI = 12'hFFF,
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 64,
  localparam int unsigned DW = BYTE_W * LANES,
  localparam int unsigned HALF_W = LEN_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              swap_en_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [LANES-1:0]  wr_be_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DW-1:0]     out_data_o,
  output logic [LANES-1:0]  out_mask_o,
  output logic [HALF_W-1:0] len_lo_o,
  output logic [HALF_W-1:0] len_hi_o
);
  logic             rst_q_n;
  logic             in_win;
  logic             appends;
  logic             push;
  logic [LEN_W-1:0] len_bits;

  msg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  msg_window_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_dec (
    .addr   (wr_addr_i),
    .in_win (in_win)
  );

  msg_lane_swap #(
    .LANES (LANES)
  ) u_swap (
    .swap_en (swap_en_i),
    .din     (wr_data_i),
    .be      (wr_be_i),
    .dout    (out_data_o)
  );

  always_comb begin
    appends     = in_win && (|wr_be_i);
    out_valid_o = wr_valid_i && appends;
    out_mask_o  = wr_be_i;
    wr_ready_o  = !appends || out_ready_i;
    push        = out_valid_o && out_ready_i;
  end

  msg_len_counter #(
    .LEN_W (LEN_W),
    .LANES (LANES)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clear    (start_i),
    .add_en   (push),
    .be       (wr_be_i),
    .len_bits (len_bits)
  );

  assign len_lo_o = len_bits[HALF_W-1:0];
  assign len_hi_o = len_bits[LEN_W-1:HALF_W];
endmodule

// File: rtl/msg_packer_chk.sv
module msg_packer_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_LO = 12'h800,
  parameter logic [ADDR_W-1:0] WIN_HI = 12'hFFF,
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 64,
  localparam int unsigned DW = 8 * LANES,
  localparam int unsigned HALF_W = LEN_W / 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              start_i,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DW-1:0]     wr_data_i,
  input logic [LANES-1:0]  wr_be_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DW-1:0]     out_data_o,
  input logic [LANES-1:0]  out_mask_o,
  input logic [HALF_W-1:0] len_lo_o,
  input logic [HALF_W-1:0] len_hi_o
);
  logic             fire;
  logic             outside;
  logic [LEN_W-1:0] len;
  logic [DW-1:0]    lane_mask;

  always_comb begin
    fire    = out_valid_o && out_ready_i;
    outside = (wr_addr_i < WIN_LO) || (wr_addr_i > WIN_HI);
    len     = {len_hi_o, len_lo_o};
    for (int i = 0; i < LANES; i++) begin
      lane_mask[i*8 +: 8] = {8{wr_be_i[i]}};
    end
  end

  // R7
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid_o && !out_ready_i) |-> !wr_ready_o);

  // R6
  mask_match_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid_o |-> (wr_valid_i && (out_mask_o == wr_be_i)));

  // R2
  outside_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && outside) |-> (wr_ready_o && !out_valid_o));

  // R5
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid_o && ($countones(wr_be_i) == 1)) |-> (out_data_o == (wr_data_i & lane_mask)));

  // R8
  len_add_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && !start_i) |=> (len == $past(len) + LEN_W'(8 * $countones($past(out_mask_o)))));

  // R9
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && !fire) |=> (len == '0));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!fire && !start_i) |=> $stable(len));
endmodule

bind msg_packer msg_packer_chk #(
  .ADDR_W (ADDR_W),
  .WIN_LO (WIN_LO),
  .WIN_HI (WIN_HI),
  .LANES  (LANES),
  .LEN_W  (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .start_i     (start_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .wr_be_i     (wr_be_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_mask_o  (out_mask_o),
  .len_lo_o    (len_lo_o),
  .len_hi_o    (len_hi_o)
);

// File: tb/msg_packer_tb.sv
module msg_packer_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        swap_en_i;
  logic        wr_valid_i;
  logic        wr_ready_o;
  logic [11:0] wr_addr_i;
  logic [31:0] wr_data_i;
  logic [3:0]  wr_be_i;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [31:0] out_data_o;
  logic [3:0]  out_mask_o;
  logic [31:0] len_lo_o;
  logic [31:0] len_hi_o;

  msg_packer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .swap_en_i   (swap_en_i),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .wr_be_i     (wr_be_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_mask_o  (out_mask_o),
    .len_lo_o    (len_lo_o),
    .len_hi_o    (len_hi_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_errs   = 0;
  bit    done     = 1'b0;
  logic [63:0] exp_len;
  logic [35:0] exp_q [$];   // {mask, data}
  string       exp_tag [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word from the requirement text: list enabled bytes, optionally reversed.
  function automatic logic [31:0] model(input logic [31:0] d, input logic [3:0] be, input bit sw);
    logic [7:0] bytes [$];
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) if (be[i]) bytes.push_back(d[i*8 +: 8]);
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        if (sw) r[i*8 +: 8] = bytes.pop_back();
        else    r[i*8 +: 8] = bytes.pop_front();
      end
    end
    return r;
  endfunction

  // Monitor: pops the expected item for each completed append.
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected word", {28'h0, out_mask_o, out_data_o}, 64'h0);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(out_data_o == e[31:0], t, {32'h0, out_data_o}, {32'h0, e[31:0]});
        check(out_mask_o == e[35:32], "R6 mask", {60'h0, out_mask_o}, {60'h0, e[35:32]});
      end
    end
  end

  // Driver: one write, optional stall cycles, optional start pulse in the first stall.
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be,
                    input bit sw, input string tag, input int stall, input bit start_mid);
    bit fwd;
    fwd = (a >= 12'h800) && (be != 4'h0);
    if (fwd) begin
      exp_q.push_back({be, model(d, be, sw)});
      exp_tag.push_back(tag);
    end
    @(posedge clk); #1;
    swap_en_i = sw; wr_addr_i = a; wr_data_i = d; wr_be_i = be; wr_valid_i = 1'b1;
    if (stall > 0) out_ready_i = 1'b0;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(!wr_ready_o, "R7 ready held low", {63'h0, wr_ready_o}, 64'h0);
      check({len_hi_o, len_lo_o} == exp_len, "R7 length not counted", {len_hi_o, len_lo_o}, exp_len);
      if (start_mid && k == 0) start_i = 1'b1;
      @(posedge clk); #1;
      if (start_i) begin
        start_i = 1'b0;
        exp_len = '0;
      end
    end
    out_ready_i = 1'b1;
    @(negedge clk);
    check(wr_ready_o, {tag, " acknowledged"}, {63'h0, wr_ready_o}, 64'h1);
    if (!fwd) check(!out_valid_o, "R2/R10 no word", {63'h0, out_valid_o}, 64'h0);
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
    if (fwd) exp_len = exp_len + 64'(8 * $countones(be));
    @(negedge clk);
    check({len_hi_o, len_lo_o} == exp_len, "R8 length", {len_hi_o, len_lo_o}, exp_len);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; swap_en_i = 1'b0; wr_valid_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; wr_be_i = '0; out_ready_i = 1'b1;
    exp_len = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(len_lo_o == 0, "R11 len_lo reset", {32'h0, len_lo_o}, 64'h0);
    check(len_hi_o == 0, "R11 len_hi reset", {32'h0, len_hi_o}, 64'h0);
    check(!out_valid_o, "R11 idle valid", {63'h0, out_valid_o}, 64'h0);

    // R3: pass-through, disabled lanes zero
    wr(12'h800, 32'h44332211, 4'hF, 1'b0, "R3 full word", 0, 1'b0);
    wr(12'h804, 32'h9988BBAA, 4'h3, 1'b0, "R3 low half", 0, 1'b0);
    wr(12'hA10, 32'h44553366, 4'hA, 1'b0, "R3 sparse zeroed", 0, 1'b0);
    // R4: reversal among enabled lanes
    wr(12'h800, 32'h44332211, 4'hF, 1'b1, "R4 full swap", 0, 1'b0);
    wr(12'h802, 32'hDDCC0000, 4'hC, 1'b1, "R4 upper half", 0, 1'b0);
    wr(12'h800, 32'h77332211, 4'h7, 1'b1, "R4 three bytes", 0, 1'b0);
    wr(12'h801, 32'h44553366, 4'hA, 1'b1, "R4 sparse 1010", 0, 1'b0);
    // R5: single bytes unchanged by the setting
    wr(12'h802, 32'h12EE3456, 4'h4, 1'b1, "R5 single swap on", 0, 1'b0);
    wr(12'h802, 32'h12EE3456, 4'h4, 1'b0, "R5 single swap off", 0, 1'b0);
    // R1: window edges and address bits
    wr(12'hFFF, 32'hCAFEF00D, 4'hF, 1'b0, "R1 top of window", 0, 1'b0);
    wr(12'h801, 32'hCAFEF00D, 4'hF, 1'b0, "R1 unaligned addr", 0, 1'b0);
    // R10: zero enables in window
    wr(12'h900, 32'hFFFFFFFF, 4'h0, 1'b0, "R10 zero mask", 0, 1'b0);
    // R2: outside the window
    wr(12'h7FC, 32'h11111111, 4'hF, 1'b0, "R2 below window", 0, 1'b0);
    wr(12'h000, 32'h22222222, 4'hF, 1'b1, "R2 address zero", 0, 1'b0);

    // R9: start clears
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0; exp_len = '0;
    @(negedge clk);
    check({len_hi_o, len_lo_o} == 64'h0, "R9 start clears", {len_hi_o, len_lo_o}, 64'h0);

    // R7: stall, then R9 start during the stall
    wr(12'h800, 32'hA1B2C3D4, 4'hF, 1'b1, "R7 stalled word", 3, 1'b0);
    wr(12'h804, 32'h00E1F2A3, 4'h7, 1'b0, "R9 start during stall", 3, 1'b1);
    check(exp_len == 64'd24, "R9 only stalled bytes", exp_len, 64'd24);
    check(len_lo_o[2:0] == 3'b000, "R8 low bits zero", {61'h0, len_lo_o[2:0]}, 64'h0);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1 all words seen", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule